// File: doc/BRIEF.md
# Bridge Control Register Block

This block holds the control and status state of a host-to-expansion-bus bridge. The host sees three word registers at fixed offsets above a base address set by a parameter. A status word reports the master interrupt enable, the wait-state enable and eleven expansion interrupt lines. A second word returns the same status on a read but also changes the interrupt enable: a read clears it and a write sets it. A third word toggles the wait-state enable on every access.

The eleven interrupt lines are asynchronous. They pass through a synchronizer and become pending flags. The host interrupt output is the master enable ANDed with the OR of these flags. Two reset sources act on different bits. The power-up reset clears the interrupt enable and loads the wait-state enable from a jumper input. The synchronous system reset reloads only the wait-state enable. The host marks each bus access with a strobe. Only the rising edge of the strobe starts an access, so a strobe held high for several cycles still acts once.

Top module: `bridge_ctl_regs`

## Requirements
- R1: While rst_ni is low and after it rises, the interrupt enable (status bit 0) is 0, rdata_o is 0 and host_irq_o is 0. On the first clock edge after rst_ni rises, the wait-state enable (status bit 1) loads jumper_i.
- R2: A clock edge with sys_rst_i high loads jumper_i into the wait-state enable and leaves the interrupt enable unchanged.
- R3: A read at BASE+0x18000 or BASE+0x18001 loads rdata_o with the status word. A write to either address changes no state.
- R4: A read at BASE+0x18002 or BASE+0x18003 returns the status word with bit 0 showing the enable from before the access. The same read clears the enable.
- R5: A write to BASE+0x18002 or BASE+0x18003 sets the interrupt enable.
- R6: A read or write at BASE+0x18004 to BASE+0x18007 inverts the wait-state enable. A read there returns 0 in rdata_o. Two such accesses leave the enable as it was.
- R7: An access acts only on the rising edge of acc_strobe_i. Holding the strobe high for more cycles has no further effect.
- R8: host_irq_o is high exactly when the interrupt enable is 1 and at least one pending flag is set.
- R9: A change on irq_lines_i reaches the pending flags and host_irq_o after two clock edges.
- R10: irq_lines_i[k] is reported in status bit k+2 for k = 0 to 10. Bits 13 to 15 read 0.
- R11: An access to any other address changes no state. A read there loads 0 into rdata_o.
- R12: rdata_o changes only on the first cycle of a read access. A read updates it on the clock edge where the access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst_i | input | 1 | System reset, synchronous, active high |
| jumper_i | input | 1 | Default value for the wait-state enable |
| acc_strobe_i | input | 1 | Access strobe. Its rising edge starts an access |
| acc_we_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| irq_lines_i | input | N_IRQ | Asynchronous expansion interrupt lines |
| rdata_o | output | 16 | Data returned by the latest read |
| host_irq_o | output | 1 | Gated interrupt request to the host |

## Verification
The bench builds the block with a base of 0x20000 on a 20-bit address. This places every register well away from address zero and makes the decode compare the upper address bits after the base is added. It also lets the bench probe an address just past the toggle word. The synchronizer stays at two stages, which makes the two-edge latency of the host interrupt observable cycle by cycle. Eleven interrupt lines allow patterns that reach both ends of the pending field and the unused bits above it.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_CLR, SEL_TOG} acc_sel_e;
  localparam int unsigned STAT_OFS = 'h18000;
  localparam int unsigned CLR_OFS  = 'h18002;
  localparam int unsigned TOG_OFS  = 'h18004;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned PEND_LSB = 2;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int unsigned    AW   = 20,
  parameter logic [AW-1:0]  BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [AW-1:0] addr_i,
  output logic          start_o,
  output acc_sel_e      sel_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] STAT_A = BASE + AW'(STAT_OFS);
  localparam logic [AW-1:0] CLR_A  = BASE + AW'(CLR_OFS);
  localparam logic [AW-1:0] TOG_A  = BASE + AW'(TOG_OFS);

  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  // one access per strobe rising edge
  assign start_o = strobe_i & ~strobe_q;
  assign busy_o  = strobe_q;

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[AW-1:1] == STAT_A[AW-1:1])     sel_o = SEL_STAT;
    else if (addr_i[AW-1:1] == CLR_A[AW-1:1]) sel_o = SEL_CLR;
    else if (addr_i[AW-1:2] == TOG_A[AW-1:2]) sel_o = SEL_TOG;
  end
endmodule

// File: rtl/bcr_ctl.sv
module bcr_ctl
  import bcr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sys_rst_i,
  input  logic     jumper_i,
  input  logic     start_i,
  input  logic     we_i,
  input  acc_sel_e sel_i,
  output logic     mie_o,
  output logic     wse_o,
  output logic     boot_o
);
  logic mie_q, wse_q, boot_q;

  // boot_q loads the jumper on the first edge after power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q  <= 1'b0;
      wse_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (boot_q || sys_rst_i)
        wse_q <= jumper_i;
      else if (start_i && sel_i == SEL_TOG)
        wse_q <= ~wse_q;
      // read clears, write sets
      if (start_i && !boot_q && sel_i == SEL_CLR)
        mie_q <= we_i;
    end
  end

  assign mie_o  = mie_q;
  assign wse_o  = wse_q;
  assign boot_o = boot_q;
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bcr_pkg::*;
#(
  parameter int unsigned   ADDR_W      = 20,
  parameter logic [ADDR_W-1:0] BASE    = '0,
  parameter int unsigned   N_IRQ       = 11,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              jumper_i,
  input  logic              acc_strobe_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [N_IRQ-1:0]  irq_lines_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              host_irq_o
);
  logic             acc_start, acc_busy;
  acc_sel_e         acc_sel;
  logic             mie, wse, boot;
  logic [N_IRQ-1:0] pend;
  logic [REG_W-1:0] status, rdata_q;

  bcr_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_lines_i), .q_o(pend)
  );

  bcr_decode #(.AW(ADDR_W), .BASE(BASE)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(acc_strobe_i),
    .addr_i(acc_addr_i), .start_o(acc_start), .sel_o(acc_sel), .busy_o(acc_busy)
  );

  bcr_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .jumper_i(jumper_i),
    .start_i(acc_start), .we_i(acc_we_i), .sel_i(acc_sel),
    .mie_o(mie), .wse_o(wse), .boot_o(boot)
  );

  always_comb begin
    status = '0;
    status[0] = mie;
    status[1] = wse;
    status[PEND_LSB +: N_IRQ] = pend;
  end

  // captured before the side effect lands, so bit 0 shows the old enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (acc_start && !acc_we_i)
      rdata_q <= (acc_sel == SEL_STAT || acc_sel == SEL_CLR) ? status : '0;
  end

  assign rdata_o    = rdata_q;
  assign host_irq_o = mie & (|pend);
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk
  import bcr_pkg::*;
#(
  parameter int unsigned N_IRQ = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic             jumper_i,
  input logic             acc_strobe_i,
  input logic             acc_we_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             host_irq_o,
  input logic             start,
  input logic [1:0]       sel,
  input logic             busy,
  input logic             mie,
  input logic             wse,
  input logic             boot,
  input logic [N_IRQ-1:0] pend
);
  p_boot_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot |=> (wse == $past(jumper_i)) && !mie);

  p_sysrst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (wse == $past(jumper_i)) && (mie == $past(mie)));

  p_clr_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !acc_we_i && sel == 2'(SEL_CLR) && !boot) |=> !mie && (rdata_o[0] == $past(mie)));

  p_set_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && acc_we_i && sel == 2'(SEL_CLR) && !boot) |=> mie);

  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && sel == 2'(SEL_TOG) && !sys_rst_i && !boot) |=> (wse != $past(wse)));

  p_toggle_rd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !acc_we_i && sel == 2'(SEL_TOG)) |=> (rdata_o == '0));

  p_held_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_strobe_i && busy) |=> $stable(mie) && $stable(rdata_o));

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mie || pend == '0) |-> !host_irq_o);
endmodule

bind bridge_ctl_regs bcr_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .jumper_i(jumper_i),
  .acc_strobe_i(acc_strobe_i), .acc_we_i(acc_we_i), .rdata_o(rdata_o),
  .host_irq_o(host_irq_o), .start(acc_start), .sel(acc_sel), .busy(acc_busy),
  .mie(mie), .wse(wse), .boot(boot), .pend(pend)
);

// File: tb/sim_bridge_ctl_regs.sv
module sim_bridge_ctl_regs;
  localparam int unsigned AW = 20;
  localparam logic [AW-1:0] B = 20'h20000;
  localparam logic [AW-1:0] A_STAT = B + 20'h18000;
  localparam logic [AW-1:0] A_CLR  = B + 20'h18002;
  localparam logic [AW-1:0] A_TOG  = B + 20'h18004;

  logic clk = 0, rst_n = 0, sys_rst = 0, jumper = 1, stb = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [10:0] irq = '0;
  logic [15:0] rdata;
  logic host_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_ctl_regs #(.ADDR_W(AW), .BASE(B), .N_IRQ(11), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .jumper_i(jumper),
    .acc_strobe_i(stb), .acc_we_i(we), .acc_addr_i(addr), .irq_lines_i(irq),
    .rdata_o(rdata), .host_irq_o(host_irq)
  );

  // behavioural reference
  logic [10:0] m_s1, m_s2;
  logic m_prev, m_mie, m_wse, m_boot;
  logic [15:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_mie = 0; m_wse = 0; m_boot = 1; m_rd = 0;
    end else begin
      int off;
      bit st_hit, clr_hit, tog_hit, begin_acc;
      logic [15:0] st;
      off = int'(addr) - int'(B);
      st_hit  = (off == 'h18000 || off == 'h18001);
      clr_hit = (off == 'h18002 || off == 'h18003);
      tog_hit = (off >= 'h18004 && off <= 'h18007);
      begin_acc = stb && !m_prev;
      st = {3'b000, m_s2, m_wse, m_mie};
      if (begin_acc && !we) m_rd = (st_hit || clr_hit) ? st : 16'h0;
      if (m_boot || sys_rst) m_wse = jumper;
      else if (begin_acc && tog_hit) m_wse = !m_wse;
      if (begin_acc && !m_boot && clr_hit) m_mie = we;
      m_boot = 0; m_s2 = m_s1; m_s1 = irq; m_prev = stb;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R12 model rdata", rdata, m_rd);
    check("R8 model host_irq", {15'd0, host_irq}, {15'd0, m_mie & (|m_s2)});
  end

  task automatic access(logic [AW-1:0] a, logic w, int hold);
    @(negedge clk);
    stb = 1; addr = a; we = w;
    repeat (hold) @(negedge clk);
    stb = 0; we = 0;
  endtask

  task automatic rd_status(string tag, logic [15:0] exp);
    access(A_STAT, 0, 1);
    check(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 rdata in reset", rdata, 16'h0);
    rst_n = 1;
    idle(2);
    check("R1 host_irq after reset", {15'd0, host_irq}, 16'h0);
    rd_status("R1 status after power-up", 16'h0002);

    irq = 11'h001; idle(3);
    rd_status("R10 irq3 in bit2", 16'h0006);
    check("R8 gated off", {15'd0, host_irq}, 16'h0);

    access(A_CLR, 1, 1);
    rd_status("R5 write sets enable", 16'h0007);
    check("R8 gated on", {15'd0, host_irq}, 16'h1);

    access(A_CLR, 0, 1);
    check("R4 read returns old enable", rdata, 16'h0007);
    rd_status("R4 enable cleared", 16'h0006);

    access(A_TOG, 0, 1);
    check("R6 toggle read is zero", rdata, 16'h0);
    rd_status("R6 first toggle", 16'h0004);
    access(A_TOG + 20'd2, 1, 1);
    rd_status("R6 two toggles restore", 16'h0006);

    access(A_TOG + 20'd3, 0, 5);
    check("R7 held read zero", rdata, 16'h0);
    rd_status("R7 held strobe toggles once", 16'h0004);
    access(A_TOG + 20'd1, 1, 1);
    rd_status("R6 toggle back", 16'h0006);

    access(A_CLR + 20'd1, 1, 4);
    rd_status("R7 held write sets once", 16'h0007);
    jumper = 0;
    @(negedge clk); sys_rst = 1;
    @(negedge clk); sys_rst = 0;
    rd_status("R2 sys reset keeps enable", 16'h0005);

    irq = 11'h400; idle(3);
    rd_status("R10 irq15 in bit12", 16'h1001);
    irq = 11'h7FF; idle(3);
    rd_status("R10 all lines, top bits zero", 16'h1FFD);

    access(A_TOG + 20'd4, 0, 1);
    check("R11 unmapped read zero", rdata, 16'h0);
    rd_status("R11 unmapped no effect", 16'h1FFD);
    access(A_STAT + 20'd1, 1, 1);
    rd_status("R3 status write ignored", 16'h1FFD);
    access(A_CLR + 20'd1, 0, 1);
    check("R3 odd byte read of clear word", rdata, 16'h1FFD);
    access(A_CLR, 1, 1);

    irq = '0; idle(3);
    check("R9 quiet", {15'd0, host_irq}, 16'h0);
    irq = 11'h020;
    @(negedge clk);
    check("R9 not yet after one edge", {15'd0, host_irq}, 16'h0);
    @(negedge clk);
    check("R9 raised after two edges", {15'd0, host_irq}, 16'h1);

    @(negedge clk); rst_n = 0;
    idle(2);
    check("R1 power-up clears host_irq", {15'd0, host_irq}, 16'h0);
    rst_n = 1;
    idle(3);
    rd_status("R1 power-up clears enable, jumper off", 16'h0080);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule